// File: doc/BRIEF.md
# NAND Attribute-Space Access Strobe Sequencer

This block times the control strobes of a single read or write to the attribute memory space of a NAND flash device. A requester offers an access with a direction flag, an address and write data. The sequencer then walks through three phases. First, an address phase drives the address before any strobe. Second, a command phase holds either the active-low write strobe or the active-low read strobe low. Third, a trailing phase keeps the address, and on writes the data, stable after the strobe rises. The phase lengths come from four programmable 8-bit timing fields: lead, pulse, trail and bus-float.

The device can stretch the command phase by pulling its active-low busy line low. That line passes through a synchronizer before it is used. On writes only, a second counter keeps the data bus undriven for a programmable number of cycles from the start of the access. Read data is captured as the read strobe rises. A one-cycle completion pulse follows the trailing phase.

Top module: `nss_strobe_seq`

## Requirements
- R1: After reset, `we_n` and `oe_n` are 1, `addr_valid`, `dq_oe` and `done` are 0, and `req_ready` is 1.
- R2: An access is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The first busy cycle follows that edge, and from it `addr_valid` is 1 for (lead + 1) cycles before a strobe goes low.
- R3: The strobe is `we_n` when `req_write` = 1 and `oe_n` when `req_write` = 0; the other strobe stays at 1. Without stretching, the strobe stays low for (pulse + 1) cycles.
- R4: If the synchronized `wait_n` is 0 in the last cycle of the programmed pulse, the strobe stays low. The strobe rises at the end of the second cycle after the cycle in which `wait_n` is driven back to 1. With two synchronizer stages, a release during strobe cycle r (counted from 0) gives a strobe length of max(pulse, r + 2) + 1.
- R5: After the strobe rises, `addr_valid` stays 1 for trail cycles. `mem_addr` and `dq_out` hold the accepted values for the whole busy period.
- R6: On writes, `dq_oe` is 0 for the first bus-float busy cycles and 1 for the rest of the busy period. On reads, `dq_oe` is never 1.
- R7: A timing field of 255 acts as 254. A pulse or trail field of 0 acts as 1.
- R8: `done` is 1 for exactly one cycle, the first cycle after the last trailing cycle. In that cycle `addr_valid` is 0 and `req_ready` is 1. `req_ready` is 0 while `addr_valid` is 1.
- R9: On reads, `rd_data` takes the value of `dq_in` present in the last strobe-low cycle and holds it after `done`.
- R10: The timing fields are sampled only at acceptance. Changing them during an access does not alter any phase length of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_lead | input | TW | Address-before-strobe field |
| cfg_pulse | input | TW | Minimum strobe-low field |
| cfg_trail | input | TW | Address-after-strobe field |
| cfg_float | input | TW | Write bus-float field |
| wait_n | input | 1 | Active-low device stretch request (asynchronous) |
| mem_addr | output | ADDR_W | Address to the device |
| addr_valid | output | 1 | Address phase active (busy) |
| we_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low read strobe |
| dq_out | output | DATA_W | Write data to the bus |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | DATA_W | Read data from the bus |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `wait_n` eventually returns high. They also assume that the requester holds `rst_n` for at least one edge, so the completion, stability and single-strobe properties see a reset-cleared history. The stimulus drives every request and every `wait_n` change at the falling edge. It releases `wait_n` at a chosen strobe cycle and changes the timing fields right after acceptance, so stretching and field latching are both exercised within those assumptions.

// File: rtl/nss_pkg.sv
package nss_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_LEAD   = 2'd1,
      PH_STROBE = 2'd2,
      PH_TRAIL  = 2'd3
   } phase_t;
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 0 || STAGES > 4) $error("nss_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RESET_VAL}};
            else        sr <= (sr << 1) | STAGES'(d);
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nss_count.sv
module nss_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] value;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     value <= '0;
      else if (load)                  value <= load_val;
      else if (dec && value != '0)    value <= value - 1'b1;
   end

   assign zero = (value == '0);
endmodule

// File: rtl/nss_strobe_seq.sv
module nss_strobe_seq
   import nss_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int TW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TW-1:0]     cfg_lead,
   input  logic [TW-1:0]     cfg_pulse,
   input  logic [TW-1:0]     cfg_trail,
   input  logic [TW-1:0]     cfg_float,
   input  logic              wait_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              addr_valid,
   output logic              we_n,
   output logic              oe_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);
   localparam logic [TW-1:0] T_RSV = {TW{1'b1}};
   localparam logic [TW-1:0] T_TOP = T_RSV - 1'b1;
   localparam logic [TW-1:0] T_ONE = TW'(1);

   initial begin
      if (TW < 2)      $error("nss_strobe_seq: TW must be at least 2");
      if (ADDR_W < 1)  $error("nss_strobe_seq: ADDR_W must be positive");
      if (DATA_W < 1)  $error("nss_strobe_seq: DATA_W must be positive");
   end

   function automatic logic [TW-1:0] cap_rsv(input logic [TW-1:0] v);
      return (v == T_RSV) ? T_TOP : v;
   endfunction

   function automatic logic [TW-1:0] cap_min1(input logic [TW-1:0] v);
      logic [TW-1:0] c;
      c = cap_rsv(v);
      return (c == '0) ? T_ONE : c;
   endfunction

   phase_t            phase, phase_nx;
   logic              is_wr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [TW-1:0]     pulse_q, trail_q;
   logic              wait_ok, ph_zero, flt_zero;
   logic              accept, busy, strobe_end;
   logic              ph_load;
   logic [TW-1:0]     ph_load_val;

   assign accept     = req_valid && (phase == PH_IDLE);
   assign busy       = (phase != PH_IDLE);
   assign strobe_end = (phase == PH_STROBE) && ph_zero && wait_ok;

   nss_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wait_sync (
      .clk(clk), .rst_n(rst_n), .d(wait_n), .q(wait_ok)
   );

   always_comb begin
      ph_load     = 1'b0;
      ph_load_val = '0;
      phase_nx    = phase;
      unique case (phase)
         PH_IDLE: if (accept) begin
            ph_load     = 1'b1;
            ph_load_val = cap_rsv(cfg_lead);
            phase_nx    = PH_LEAD;
         end
         PH_LEAD: if (ph_zero) begin
            ph_load     = 1'b1;
            ph_load_val = pulse_q;
            phase_nx    = PH_STROBE;
         end
         PH_STROBE: if (strobe_end) begin
            ph_load     = 1'b1;
            ph_load_val = trail_q - 1'b1;
            phase_nx    = PH_TRAIL;
         end
         PH_TRAIL: if (ph_zero) phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   nss_count #(.W(TW)) u_phase_cnt (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_load_val),
      .dec(busy), .zero(ph_zero)
   );

   nss_count #(.W(TW)) u_float_cnt (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cap_rsv(cfg_float)),
      .dec(busy), .zero(flt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         is_wr   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         pulse_q <= T_ONE;
         trail_q <= T_ONE;
         rd_data <= '0;
         done    <= 1'b0;
      end else begin
         phase <= phase_nx;
         done  <= (phase == PH_TRAIL) && ph_zero;
         if (accept) begin
            is_wr   <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            pulse_q <= cap_min1(cfg_pulse);
            trail_q <= cap_min1(cfg_trail);
         end
         if (strobe_end && !is_wr) rd_data <= dq_in;
      end
   end

   assign req_ready  = (phase == PH_IDLE);
   assign addr_valid = busy;
   assign mem_addr   = addr_q;
   assign dq_out     = wdata_q;
   assign we_n       = !((phase == PH_STROBE) && is_wr);
   assign oe_n       = !((phase == PH_STROBE) && !is_wr);
   assign dq_oe      = busy && is_wr && flt_zero;
endmodule

// File: rtl/nss_strobe_chk.sv
module nss_strobe_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              addr_valid,
   input logic              we_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe,
   input logic              done
);
   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));

   assert_strobe_has_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !oe_n) |-> addr_valid);

   assert_lead_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(we_n) || $fell(oe_n)) |-> $past(addr_valid));

   assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && $past(addr_valid)) |-> ($stable(mem_addr) && $stable(dq_out)));

   assert_trail_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(we_n) || $rose(oe_n)) |-> addr_valid);

   assert_float_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (addr_valid && oe_n));

   assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!addr_valid && $past(addr_valid) && req_ready));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> !req_ready);
endmodule

bind nss_strobe_seq nss_strobe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
   .addr_valid(addr_valid), .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out),
   .dq_oe(dq_oe), .done(done)
);

// File: tb/tb_nss_strobe_seq.sv
module tb_nss_strobe_seq;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [7:0]    cfg_lead = '0, cfg_pulse = '0, cfg_trail = '0, cfg_float = '0;
   logic          wait_n = 1'b1;
   logic [AW-1:0] mem_addr;
   logic          addr_valid, we_n, oe_n, dq_oe, done;
   logic [DW-1:0] dq_out, rd_data;
   logic [DW-1:0] dq_in = '0;

   int n_vec = 0;
   int n_bad = 0;
   int seq   = 0;

   always #5 clk = ~clk;

   nss_strobe_seq #(.ADDR_W(AW), .DATA_W(DW), .TW(8), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_lead(cfg_lead), .cfg_pulse(cfg_pulse), .cfg_trail(cfg_trail),
      .cfg_float(cfg_float), .wait_n(wait_n), .mem_addr(mem_addr),
      .addr_valid(addr_valid), .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out),
      .dq_oe(dq_oe), .dq_in(dq_in), .rd_data(rd_data), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int cap_f(input int v);
      return (v == 255) ? 254 : v;
   endfunction

   function automatic int min1_f(input int v);
      int c;
      c = cap_f(v);
      return (c == 0) ? 1 : c;
   endfunction

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 13 + 5) & 255);
   endfunction

   // rel < 0: no stretch; otherwise wait_n held low, released in strobe cycle rel
   task automatic run_access(input bit wr, input int s, input int w, input int h,
                             input int z, input int rel);
      int se, we, sl, he, ze, total;
      int k, first_st, last_st, st_cnt, av_cnt, first_oe, done_k;
      int bad_sel, bad_addr, bad_data;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      seq++;
      a = AW'(seq * 37 + 11);
      d = DW'(seq * 29 + 3);
      @(negedge clk);
      wait_n = (rel >= 0) ? 1'b0 : 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      cfg_lead = 8'(s); cfg_pulse = 8'(w); cfg_trail = 8'(h); cfg_float = 8'(z);
      @(posedge clk);
      k = 0; first_st = -1; last_st = -1; st_cnt = 0; av_cnt = 0; first_oe = -1;
      done_k = -1; bad_sel = 0; bad_addr = 0; bad_data = 0;
      while (k < 4000) begin
         @(negedge clk);
         if (k == 0) begin
            req_valid = 1'b0;
            // R10: scramble the fields after acceptance
            cfg_lead = ~cfg_lead; cfg_pulse = ~cfg_pulse;
            cfg_trail = ~cfg_trail; cfg_float = ~cfg_float;
         end
         if (!we_n || !oe_n) begin
            if (first_st < 0) first_st = k;
            st_cnt++;
            last_st = k;
            if ((wr && !oe_n) || (!wr && !we_n)) bad_sel++;
         end
         if (addr_valid) begin
            av_cnt++;
            if (mem_addr != a) bad_addr++;
            if (wr && dq_out != d) bad_data++;
         end
         if (dq_oe && first_oe < 0) first_oe = k;
         if (done) begin
            done_k = k;
            break;
         end
         dq_in = pat(k);
         if (rel >= 0 && first_st >= 0 && k == first_st + rel) wait_n = 1'b1;
         k++;
      end
      se = cap_f(s) + 1;
      we = min1_f(w);
      sl = (rel >= 0) ? (((we > rel + 2) ? we : rel + 2) + 1) : we + 1;
      he = min1_f(h);
      ze = cap_f(z);
      total = se + sl + he;
      chk(first_st == se, "R2,R7,R10 lead length", first_st, se);
      chk(st_cnt == sl && last_st - first_st + 1 == st_cnt,
          (rel >= 0) ? "R4 stretched strobe length" : "R3,R7,R10 strobe length", st_cnt, sl);
      chk(bad_sel == 0, "R3 strobe selection", bad_sel, 0);
      chk(av_cnt == total, "R5,R7 trail length", av_cnt - se - st_cnt, he);
      chk(bad_addr == 0 && bad_data == 0, "R5 address/data held", bad_addr + bad_data, 0);
      chk(done_k == total, "R8 done cycle", done_k, total);
      if (wr)
         chk(first_oe == ((ze < total) ? ze : -1), "R6 write float", first_oe,
             (ze < total) ? ze : -1);
      else
         chk(first_oe == -1, "R6 read never drives", first_oe, -1);
      if (!wr)
         chk(rd_data == pat(last_st), "R9 read capture", int'(rd_data), int'(pat(last_st)));
      @(negedge clk);
      chk(!done && !addr_valid && req_ready, "R8 done single pulse", int'(done), 0);
      if (!wr)
         chk(rd_data == pat(last_st), "R9 read data held", int'(rd_data), int'(pat(last_st)));
      wait_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(we_n && oe_n, "R1 strobes idle high", int'({we_n, oe_n}), 3);
      chk(!addr_valid && !dq_oe && !done, "R1 outputs low in reset",
          int'({addr_valid, dq_oe, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && we_n && oe_n && !addr_valid && !dq_oe && !done,
          "R1 idle after reset", int'({req_ready, we_n, oe_n, addr_valid, dq_oe, done}), 6'b111000);

      for (int wr = 0; wr < 2; wr++)
         for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
               for (int h = 0; h < 4; h++)
                  for (int z = 0; z < (wr ? 5 : 2); z++)
                     run_access(wr[0], s, w, h, z, -1);

      for (int wr = 0; wr < 2; wr++)
         for (int w = 0; w < 4; w++)
            for (int r = 0; r < 6; r++)
               run_access(wr[0], 1, w, 1, 0, r);

      // R7 reserved and zero encodings
      run_access(1'b1, 255, 255, 255, 255, -1);
      run_access(1'b0, 254, 254, 254, 254, -1);
      run_access(1'b1, 0, 0, 0, 255, -1);
      run_access(1'b1, 0, 255, 0, 3, -1);
      run_access(1'b0, 255, 0, 255, 0, 4);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule